// File: doc/BRIEF.md
# Packet Command Host Sequencer

This block is the host side of a packet command transfer to a storage device on a parallel ATA register bus. One start pulse launches the full exchange. The block writes the device-control register with the chosen interrupt-mask setting and issues the packet opcode. It then waits out the settle time, polls status until the device asks for the packet, and pushes the twelve command bytes as six 16-bit data writes. After that it either polls or waits for the device interrupt, which is chosen by the mask bit. It then reads status until the device decides between completion, failure or a data phase.

Every register access is a single-cycle bus operation. The sequencer drives the strobe, direction, register select and write data, and samples read data in the same cycle. The data phase is handed off: the block raises a flag and resumes status polling when a separate agent acknowledges. A 3-bit code reports which protocol phase is active, and a one-cycle done pulse with an error qualifier reports the result.

Top module: `pkt_cmd_host`

## Requirements
- R1: After reset the block is idle. The state code is 0, and no bus cycle, done, error or data-phase flag is active.
- R2: When start is sampled high in idle, the packet bytes and mask bit are captured. The next cycle is a write to select 8 (device control) with data 0x0008 plus the mask bit placed at bit 1.
- R3: The cycle after the device-control write is a write of 0x00A0 to select 7 (command).
- R4: After the opcode write, no bus cycle occurs for SETTLE_CYC = ceil(SETTLE_NS / CLK_NS) cycles.
- R5: After the settle time, a status read of select 7 happens on every cycle. This continues until the read data shows bit 7 (busy) at 0 and bit 3 (data request) at 1.
- R6: Next come exactly six writes to select 0 on consecutive cycles. Word i carries captured byte 2i+1 in bits 15:8 and byte 2i in bits 7:0, where byte 0 is packet input bits 7:0.
- R7: After the last word, a mask of 1 leads directly to the alternate-status read. A mask of 0 leads to a wait with no bus cycle until the device interrupt input is sampled high.
- R8: Exactly one read of select 8 (alternate status) is made and its data is ignored. After it, status reads of select 7 repeat every cycle while bit 7 is 1.
- R9: A status read with bits 7, 3 and 0 all clear ends the command. Done is high for one cycle with error low, and the block returns to idle.
- R10: A status read with bit 7 clear and bit 0 (error) set ends the command with done and error both high for one cycle, whatever bit 3 holds.
- R11: A status read with bit 7 clear, bit 3 set and bit 0 clear raises the data-phase flag with no bus cycles. The flag holds until the acknowledge input is sampled high, and status reads resume on the next cycle without another alternate read.
- R12: A start pulse, or a change of the packet or mask inputs, has no effect while the block is not idle.
- R13: The state code is 0 when idle and 1 during setup (control write, opcode, settle). It is 2 while polling for the packet request, 3 while sending, 4 while waiting for the interrupt, 5 while polling after the packet and 6 in the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, honoured only in idle |
| pktIn | input | 96 | Twelve command bytes, byte 0 in bits 7:0 |
| irqMask | input | 1 | 1 = poll after packet, 0 = wait for interrupt |
| devIrq | input | 1 | Device interrupt request |
| xferAck | input | 1 | Data-phase completion acknowledge |
| rdData | input | 8 | Register read data, valid in the read cycle |
| busValid | output | 1 | Bus operation this cycle |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | 4 | Register select |
| busWrData | output | 16 | Write data |
| stateCode | output | 3 | Protocol phase code |
| dataPhase | output | 1 | Data phase handed off |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Completion was a failure (with done) |

## Verification
The bench uses the default parameters: CLK_NS = 10 and SETTLE_NS = 400. That gives a 40-cycle settle window, so every bus-idle cycle of the delay is compared one by one, along with both ends of the window. It uses twelve distinct packet bytes, so any swap of the byte order within a word or any reordering of words shows up as a data mismatch. A scripted device returns busy, request, error and combined status codes, and it answers alternate reads with the error bit set. This brings within reach the polling loops, the priority of error over data request, the interrupt wait and the data-phase return path.

// File: rtl/pkt_host_pkg.sv
package pkt_host_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVCTL,
    ST_OPCODE,
    ST_SETTLE,
    ST_CHKA,
    ST_SEND,
    ST_IRQW,
    ST_ALT,
    ST_CHKB,
    ST_XFER
  } hostState_t;

  typedef struct packed {
    logic pktLoad;
    logic wrDevCtl;
    logic wrOpcode;
    logic wrWord;
    logic rdStatus;
    logic rdAlt;
  } busStrobe_t;

  localparam logic [3:0] SEL_DATA    = 4'h0;
  localparam logic [3:0] SEL_CMDSTAT = 4'h7;
  localparam logic [3:0] SEL_CTLALT  = 4'h8;

  localparam logic [7:0]  OPC_PACKET  = 8'hA0;
  localparam logic [15:0] DEVCTL_BASE = 16'h0008;

  localparam int STAT_BUSY = 7;
  localparam int STAT_DRQ  = 3;
  localparam int STAT_ERR  = 0;

endpackage

// File: rtl/pkt_host_ctrl.sv
module pkt_host_ctrl
  import pkt_host_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int SETTLE_NS = 400,
  parameter int PKT_WORDS = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       maskLatched,
  input  logic       devIrq,
  input  logic       xferAck,
  input  logic [7:0] statusIn,
  output busStrobe_t strobe,
  output logic [((PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1)-1:0] wordIdx,
  output logic [2:0] stateCode,
  output logic       dataPhase,
  output logic       done,
  output logic       error
);

  localparam int SETTLE_RAW = (SETTLE_NS + CLK_NS - 1) / CLK_NS;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int CNT_W      = $clog2(SETTLE_CYC + 1);
  localparam int IDX_W      = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PKT_WORDS - 1);

  hostState_t       stateQ, stateD;
  logic [CNT_W-1:0] cntQ;
  logic [IDX_W-1:0] idxQ;
  logic             doneQ, errQ;

  logic busyBit, drqBit, errBit;
  assign busyBit = statusIn[STAT_BUSY];
  assign drqBit  = statusIn[STAT_DRQ];
  assign errBit  = statusIn[STAT_ERR];

  logic endOk, endErr;
  assign endErr = (stateQ == ST_CHKB) && !busyBit && errBit;
  assign endOk  = (stateQ == ST_CHKB) && !busyBit && !errBit && !drqBit;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (start) stateD = ST_DEVCTL;
      ST_DEVCTL: stateD = ST_OPCODE;
      ST_OPCODE: stateD = ST_SETTLE;
      ST_SETTLE: if (cntQ == CNT_LAST) stateD = ST_CHKA;
      ST_CHKA:   if (!busyBit && drqBit) stateD = ST_SEND;
      ST_SEND:   if (idxQ == IDX_LAST) stateD = maskLatched ? ST_ALT : ST_IRQW;
      ST_IRQW:   if (devIrq) stateD = ST_ALT;
      ST_ALT:    stateD = ST_CHKB;
      ST_CHKB: begin
        if (endErr || endOk)        stateD = ST_IDLE;
        else if (!busyBit && drqBit) stateD = ST_XFER;
      end
      ST_XFER:   if (xferAck) stateD = ST_CHKB;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      idxQ   <= '0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_OPCODE)      cntQ <= '0;
      else if (stateQ == ST_SETTLE) cntQ <= cntQ + 1'b1;
      if (stateQ == ST_CHKA)        idxQ <= '0;
      else if (stateQ == ST_SEND)   idxQ <= idxQ + 1'b1;
      doneQ <= endOk || endErr;
      errQ  <= endErr;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.pktLoad  = (stateQ == ST_IDLE) && start;
    strobe.wrDevCtl = (stateQ == ST_DEVCTL);
    strobe.wrOpcode = (stateQ == ST_OPCODE);
    strobe.wrWord   = (stateQ == ST_SEND);
    strobe.rdStatus = (stateQ == ST_CHKA) || (stateQ == ST_CHKB);
    strobe.rdAlt    = (stateQ == ST_ALT);
  end

  always_comb begin
    unique case (stateQ)
      ST_DEVCTL, ST_OPCODE, ST_SETTLE: stateCode = 3'd1;
      ST_CHKA:                         stateCode = 3'd2;
      ST_SEND:                         stateCode = 3'd3;
      ST_IRQW:                         stateCode = 3'd4;
      ST_ALT, ST_CHKB:                 stateCode = 3'd5;
      ST_XFER:                         stateCode = 3'd6;
      default:                         stateCode = 3'd0;
    endcase
  end

  assign wordIdx   = idxQ;
  assign dataPhase = (stateQ == ST_XFER);
  assign done      = doneQ;
  assign error     = errQ;

  AST_CTL_THEN_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDevCtl |=> strobe.wrOpcode); // R3

  AST_LAST_WORD_BRANCH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrWord && wordIdx == IDX_LAST) |=> (strobe.rdAlt || stateCode == 3'd4)); // R7

  AST_IRQ_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd4 && !devIrq) |=> (stateCode == 3'd4 && !$past(strobe.rdAlt))); // R7

  AST_ALT_THEN_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAlt |=> (strobe.rdStatus && !strobe.rdAlt)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_ERROR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done); // R10

  AST_XFER_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    dataPhase |-> !(strobe.rdStatus || strobe.wrWord || strobe.rdAlt)); // R11

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != 3'd0) |=> !strobe.wrDevCtl); // R12

endmodule

// File: rtl/pkt_host_dp.sv
module pkt_host_dp
  import pkt_host_pkg::*;
#(
  parameter int PKT_WORDS = 6,
  localparam int IDX_W    = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  busStrobe_t             strobe,
  input  logic [IDX_W-1:0]       wordIdx,
  input  logic [PKT_WORDS*16-1:0] pktIn,
  input  logic                   irqMask,
  output logic                   maskLatched,
  output logic                   busValid,
  output logic                   busWrite,
  output logic [3:0]             busAddr,
  output logic [15:0]            busWrData
);

  logic [PKT_WORDS*16-1:0] pktQ;
  logic                    maskQ;
  logic [15:0]             wordArr [PKT_WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktQ  <= '0;
      maskQ <= 1'b0;
    end else if (strobe.pktLoad) begin
      pktQ  <= pktIn;
      maskQ <= irqMask;
    end
  end

  for (genvar g = 0; g < PKT_WORDS; g++) begin : g_word
    assign wordArr[g] = pktQ[16*g +: 16];
  end

  assign maskLatched = maskQ;
  assign busWrite    = strobe.wrDevCtl | strobe.wrOpcode | strobe.wrWord;
  assign busValid    = busWrite | strobe.rdStatus | strobe.rdAlt;

  always_comb begin
    busAddr = SEL_DATA;
    if (strobe.wrDevCtl || strobe.rdAlt)        busAddr = SEL_CTLALT;
    else if (strobe.wrOpcode || strobe.rdStatus) busAddr = SEL_CMDSTAT;
  end

  always_comb begin
    busWrData = 16'h0000;
    if (strobe.wrWord)        busWrData = wordArr[wordIdx];
    else if (strobe.wrOpcode) busWrData = {8'h00, OPC_PACKET};
    else if (strobe.wrDevCtl) busWrData = DEVCTL_BASE | {14'h0, maskQ, 1'b0};
  end

  AST_PKT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrWord || strobe.rdStatus) |=> $stable(pktQ)); // R12

  AST_WORD_TO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == SEL_DATA) |-> strobe.wrWord); // R6

endmodule

// File: rtl/pkt_cmd_host.sv
module pkt_cmd_host
  import pkt_host_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int SETTLE_NS = 400,
  parameter int PKT_BYTES = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [PKT_BYTES*8-1:0] pktIn,
  input  logic                 irqMask,
  input  logic                 devIrq,
  input  logic                 xferAck,
  input  logic [7:0]           rdData,
  output logic                 busValid,
  output logic                 busWrite,
  output logic [3:0]           busAddr,
  output logic [15:0]          busWrData,
  output logic [2:0]           stateCode,
  output logic                 dataPhase,
  output logic                 done,
  output logic                 error
);

  localparam int PKT_WORDS = PKT_BYTES / 2;
  localparam int IDX_W     = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;

  busStrobe_t       strobe;
  logic [IDX_W-1:0] wordIdx;
  logic             maskLatched;

  pkt_host_ctrl #(
    .CLK_NS(CLK_NS), .SETTLE_NS(SETTLE_NS), .PKT_WORDS(PKT_WORDS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .maskLatched(maskLatched),
    .devIrq(devIrq), .xferAck(xferAck), .statusIn(rdData),
    .strobe(strobe), .wordIdx(wordIdx), .stateCode(stateCode),
    .dataPhase(dataPhase), .done(done), .error(error)
  );

  pkt_host_dp #(
    .PKT_WORDS(PKT_WORDS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx),
    .pktIn(pktIn[PKT_WORDS*16-1:0]), .irqMask(irqMask), .maskLatched(maskLatched),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWrData(busWrData)
  );

endmodule

// File: tb/pkt_cmd_host_tb_top.sv
module pkt_cmd_host_tb_top;

  localparam int CLK_NS    = 10;
  localparam int SETTLE_NS = 400;
  localparam int SET_CYC   = (SETTLE_NS + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [95:0] pktIn = '0;
  logic        irqMask = 1'b0;
  logic        devIrq = 1'b0;
  logic        xferAck = 1'b0;
  logic [7:0]  rdData;
  logic        busValid, busWrite, dataPhase, done, error;
  logic [3:0]  busAddr;
  logic [15:0] busWrData;
  logic [2:0]  stateCode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  // scripted device: successive status reads walk through this list
  logic [7:0] script [0:15];
  int         sIdx = 0;
  initial begin
    for (int i = 0; i < 16; i++) script[i] = 8'h00;
    script[0] = 8'h80; script[1] = 8'h80; script[2] = 8'h08;
    script[3] = 8'h80; script[4] = 8'h00;
    script[5] = 8'h88; script[6] = 8'h08;
    script[7] = 8'h80; script[8] = 8'h09;
    script[9] = 8'h08; script[10] = 8'h08; script[11] = 8'h00;
  end
  logic statusRd;
  assign statusRd = busValid && !busWrite && busAddr == 4'h7;
  // alternate reads return the error bit set; it must be ignored (R8)
  assign rdData = statusRd ? script[sIdx] : 8'h01;
  always @(posedge clk) if (statusRd) sIdx <= sIdx + 1;

  pkt_cmd_host #(.CLK_NS(CLK_NS), .SETTLE_NS(SETTLE_NS), .PKT_BYTES(12)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .pktIn(pktIn), .irqMask(irqMask),
    .devIrq(devIrq), .xferAck(xferAck), .rdData(rdData),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWrData(busWrData), .stateCode(stateCode), .dataPhase(dataPhase),
    .done(done), .error(error)
  );

  // behavioural reference: phase number plus counters
  int          mPh = 0;
  int          mCnt = 0;
  int          mW = 0;
  bit          mMask = 0;
  bit          mDone = 0;
  bit          mErr = 0;
  logic [7:0]  mBytes [0:11];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh <= 0; mCnt <= 0; mW <= 0; mDone <= 0; mErr <= 0; mMask <= 0;
    end else begin
      logic [7:0] st;
      st = script[sIdx];
      mDone <= 0; mErr <= 0;
      case (mPh)
        0: if (start) begin
             mPh <= 1; mMask <= irqMask;
             for (int b = 0; b < 12; b++) mBytes[b] <= pktIn[8*b +: 8];
           end
        1: mPh <= 2;
        2: begin mPh <= 3; mCnt <= 0; end
        3: if (mCnt == SET_CYC - 1) mPh <= 4; else mCnt <= mCnt + 1;
        4: if (!st[7] && st[3]) begin mPh <= 5; mW <= 0; end
        5: if (mW == 5) mPh <= mMask ? 7 : 6; else mW <= mW + 1;
        6: if (devIrq) mPh <= 7;
        7: mPh <= 8;
        8: if (!st[7]) begin
             if (st[0]) begin mPh <= 0; mDone <= 1; mErr <= 1; end
             else if (st[3]) mPh <= 9;
             else begin mPh <= 0; mDone <= 1; end
           end
        9: if (xferAck) mPh <= 8;
        default: mPh <= 0;
      endcase
    end
  end

  function automatic string tagOf(int ph);
    case (ph)
      1: return "R2";  2: return "R3";  3: return "R4";  4: return "R5";
      5: return "R6";  6: return "R7";  7: return "R8";  8: return "R8";
      9: return "R11"; default: return "R9";
    endcase
  endfunction

  function automatic int codeOf(int ph);
    case (ph)
      1, 2, 3: return 1;  4: return 2;  5: return 3;  6: return 4;
      7, 8: return 5;  9: return 6;  default: return 0;
    endcase
  endfunction

  int doneCnt = 0, errCnt = 0, wordCnt = 0, altCnt = 0;
  logic compareOn = 1'b0;

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (compareOn) begin
      logic        eV, eW;
      logic [3:0]  eA;
      logic [15:0] eD;
      eV = 0; eW = 0; eA = 4'h0; eD = 16'h0;
      case (mPh)
        1: begin eV = 1; eW = 1; eA = 4'h8; eD = 16'h0008 | {14'h0, mMask, 1'b0}; end
        2: begin eV = 1; eW = 1; eA = 4'h7; eD = 16'h00A0; end
        4, 8: begin eV = 1; eA = 4'h7; end
        5: begin eV = 1; eW = 1; eA = 4'h0; eD = {mBytes[2*mW+1], mBytes[2*mW]}; end
        7: begin eV = 1; eA = 4'h8; end
        default: ;
      endcase
      checks++;
      if (stateCode !== 3'(codeOf(mPh))) begin
        fails++;
        $display("FAIL R13 stateCode actual %0d expected %0d", stateCode, codeOf(mPh));
      end else if (busValid !== eV || (eV && (busWrite !== eW || busAddr !== eA)) ||
                   (eV && eW && busWrData !== eD) || dataPhase !== (mPh == 9) ||
                   done !== mDone || error !== mErr) begin
        fails++;
        $display("FAIL %s bus v/w/a/d/dp/dn/er actual %b/%b/%h/%h/%b/%b/%b expected %b/%b/%h/%h/%b/%b/%b",
                 tagOf(mPh), busValid, busWrite, busAddr, busWrData, dataPhase, done, error,
                 eV, eW, eA, eD, mPh == 9, mDone, mErr);
      end
      if (done) doneCnt++;
      if (error) errCnt++;
      if (busValid && busWrite && busAddr == 4'h0) wordCnt++;
      if (busValid && !busWrite && busAddr == 4'h8) altCnt++;
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic launch(bit mask, int seed);
    @(negedge clk);
    irqMask = mask;
    for (int b = 0; b < 12; b++) pktIn[8*b +: 8] = 8'(seed + 17 * b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(int base);
    int n = 0;
    while (doneCnt == base && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busValid", busValid, 0);
    check("R1 stateCode", stateCode, 0);
    check("R1 done", done, 0);
    rstN = 1'b1;
    compareOn = 1'b1;

    // scenario A: mask set, polling path, clean finish (R2..R9)
    wordCnt = 0; altCnt = 0;
    launch(1'b1, 3);
    waitDone(0);
    check("R9 done count", doneCnt, 1);
    check("R9 error count", errCnt, 0);
    check("R6 word writes", wordCnt, 6);
    check("R8 alt reads", altCnt, 1);

    // scenario B: mask clear, interrupt wait, error finish, stray start (R7 R10 R12)
    wordCnt = 0; altCnt = 0;
    launch(1'b0, 91);
    repeat (10) @(negedge clk);
    start = 1'b1; pktIn = ~pktIn; irqMask = 1'b1;   // R12 stray launch
    @(negedge clk);
    start = 1'b0;
    while (stateCode != 3'd4) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R7 still waiting", stateCode, 4);
    check("R7 no alt yet", altCnt, 0);
    devIrq = 1'b1;
    @(negedge clk);
    devIrq = 1'b0;
    waitDone(1);
    check("R10 done count", doneCnt, 2);
    check("R10 error count", errCnt, 1);
    check("R12 words once", wordCnt, 6);

    // scenario C: data phase hand-off (R11)
    altCnt = 0;
    launch(1'b1, 200);
    while (!dataPhase) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R11 hold", dataPhase, 1);
    xferAck = 1'b1;
    @(negedge clk);
    xferAck = 1'b0;
    check("R11 resumed", stateCode, 5);
    waitDone(2);
    check("R11 done count", doneCnt, 3);
    check("R11 error count", errCnt, 1);
    check("R11 single alt", altCnt, 1);
    check("R1 idle after", stateCode, 0);

    compareOn = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule